// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking two in-memory tables. A root table covers the whole address space with 1024 four-byte entries. Each root entry points to a leaf table of 1024 four-byte entries, and each leaf entry maps one 4 KiB page. User and supervisor accesses each start from their own root frame register. Each mode also has its own enable bit. When a mode's enable bit is clear, that mode's addresses come out unchanged.

A request carries the address, the mode and the direction (read or write). The walker reads the root entry and then the leaf entry through a single-word memory port. It checks the valid bit and the read-only bit at each level. On a permitted access it writes the leaf entry back with the referenced flag set, and on a write also the dirty flag, but only when one of those flags was clear. It then pulses `done` with the physical address and the no-cache flag, or with a fault code. Three fault classes, plus a summary bit, are recorded in sticky status flags. Software clears them through a small configuration port. The walker handles one request at a time.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready` is 1, `done` and `mem_req` are 0, and `stat_word` is zero, so both modes are untranslated.
- R2: If the enable bit of the request's mode is clear (bit 1 of the control value for supervisor, bit 0 for user), `done` rises one cycle after acceptance. `rsp_pa` equals the virtual address and `rsp_fault` is 0. No memory access is made.
- R3: The root entry is read at address {mode's root frame, VA[31:22], 2'b00}. `cfg_sel` 0 loads the supervisor root frame and `cfg_sel` 1 loads the user root frame, each from `cfg_wdata[19:0]`.
- R4: A root entry with bit 1 clear ends the walk with `rsp_fault` = 1 (table fault), 3 cycles after acceptance. It sets status bits 15 and 3. Bit 0 of the root entry is ignored.
- R5: The leaf entry is read at {root entry[31:12], VA[21:12], 2'b00}. A leaf entry with bit 0 clear ends the walk with `rsp_fault` = 2 (page fault), 5 cycles after acceptance. It sets status bits 14 and 3. Bit 1 of the leaf entry is ignored.
- R6: A write whose root entry has bit 2 set, or whose leaf entry has bit 2 set, ends with `rsp_fault` = 3 (protection fault) 5 cycles after acceptance. It sets status bits 13 and 3, and no memory write is made. Reads are not affected by bit 2.
- R7: On success `rsp_fault` is 0, `rsp_pa` = {leaf entry[31:12], VA[11:0]} and `rsp_inhibit` equals leaf entry bit 6. On any fault, `rsp_pa` and `rsp_inhibit` are zero.
- R8: On success the leaf entry is rewritten at its own address with bit 3 set, and also bit 4 set for a write. The rewrite happens only if this changes the entry, which gives a latency of 7 cycles instead of 5.
- R9: Status bits 15, 14, 13 and 3 stay set until a `cfg_sel` 2 write carries a 1 in that bit position. The same write loads the enable bits 1:0 from `cfg_wdata[1:0]`.
- R10: `req_ready` is 0 from acceptance until `done`, and `done` is high for exactly one cycle.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 supervisor root, 1 user root, 2 control/status |
| cfg_wdata | input | 20 | Configuration write data |
| stat_word | output | 16 | Sticky fault flags and mode enables |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_write | input | 1 | 1 = write access |
| done | output | 1 | One-cycle completion pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 table, 2 page, 3 protection |
| rsp_inhibit | output | 1 | Page marked not cacheable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |

## Verification
Each memory access takes two cycles against the bench's memory model. So `done` is due 1 cycle after acceptance for a pass-through, 3 cycles for a table fault, 5 cycles for a leaf-level result, and 7 cycles when a rewrite is needed. The bench counts falling edges from the accepting edge until `done` and compares that count with the value for the expected outcome. It reads `rsp_*` and `stat_word` on that same falling edge. It also checks the memory write count and the stored leaf entry, which shows whether a rewrite happened.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW  = 32;
  localparam int PGW = 12;
  localparam int IXW = 10;
  localparam int FNW = AW - PGW;
  localparam int SW  = 16;

  // root entry fields
  localparam int ROOT_V  = 1;
  localparam int ROOT_RO = 2;
  // leaf entry fields
  localparam int LEAF_V   = 0;
  localparam int LEAF_RO  = 2;
  localparam int LEAF_REF = 3;
  localparam int LEAF_DRT = 4;
  localparam int LEAF_NC  = 6;
  // status word fields
  localparam int ST_TF = 15;
  localparam int ST_PF = 14;
  localparam int ST_PR = 13;
  localparam int ST_AN = 3;
  localparam int ST_SE = 1;
  localparam int ST_UE = 0;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_PAGE  = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  function automatic logic [AW-1:0] root_slot(input logic [FNW-1:0] root,
                                               input logic [AW-1:0] va);
    return {root, va[AW-1 -: IXW], 2'b00};
  endfunction

  function automatic logic [AW-1:0] leaf_slot(input logic [FNW-1:0] tbl,
                                               input logic [AW-1:0] va);
    return {tbl, va[PGW+IXW-1 -: IXW], 2'b00};
  endfunction

  function automatic logic [AW-1:0] phys_of(input logic [AW-1:0] leaf,
                                             input logic [AW-1:0] va);
    return {leaf[AW-1:PGW], va[PGW-1:0]};
  endfunction

  function automatic logic [AW-1:0] touch(input logic [AW-1:0] leaf,
                                           input logic wr);
    logic [AW-1:0] t;
    t = leaf;
    t[LEAF_REF] = 1'b1;
    if (wr) t[LEAF_DRT] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
(
  input  logic          root_ro,
  input  logic [AW-1:0] leaf,
  input  logic [AW-1:0] va,
  input  logic          wr,
  output logic          leaf_ok,
  output logic          prot_hit,
  output logic [AW-1:0] leaf_new,
  output logic          need_wb,
  output logic [AW-1:0] pa,
  output logic          nc
);
  always_comb begin
    leaf_ok  = leaf[LEAF_V];
    prot_hit = wr && (root_ro || leaf[LEAF_RO]);
    leaf_new = touch(leaf, wr);
    need_wb  = (leaf_new != leaf);
    pa       = phys_of(leaf, va);
    nc       = leaf[LEAF_NC];
  end
endmodule

// File: rtl/ptw_cfg.sv
module ptw_cfg
  import ptw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [FNW-1:0] cfg_wdata,
  input  logic           fault_evt,
  input  logic [1:0]     fault_kind,
  output logic [FNW-1:0] sup_root,
  output logic [FNW-1:0] usr_root,
  output logic           en_sup,
  output logic           en_usr,
  output logic [SW-1:0]  stat_word
);
  logic [FNW-1:0] sup_q, usr_q;
  logic [1:0]     en_q;
  logic           tf_q, pf_q, pr_q, an_q;
  logic           ctl_hit;
  logic           set_tf, set_pf, set_pr;

  assign ctl_hit = cfg_we && (cfg_sel == 2'd2);
  assign set_tf  = fault_evt && (fault_kind == FLT_TABLE);
  assign set_pf  = fault_evt && (fault_kind == FLT_PAGE);
  assign set_pr  = fault_evt && (fault_kind == FLT_PROT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q <= '0;
      usr_q <= '0;
      en_q  <= '0;
      tf_q  <= 1'b0;
      pf_q  <= 1'b0;
      pr_q  <= 1'b0;
      an_q  <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == 2'd0) sup_q <= cfg_wdata;
      if (cfg_we && cfg_sel == 2'd1) usr_q <= cfg_wdata;
      if (ctl_hit) en_q <= cfg_wdata[1:0];
      tf_q <= set_tf    || (tf_q && !(ctl_hit && cfg_wdata[ST_TF]));
      pf_q <= set_pf    || (pf_q && !(ctl_hit && cfg_wdata[ST_PF]));
      pr_q <= set_pr    || (pr_q && !(ctl_hit && cfg_wdata[ST_PR]));
      an_q <= fault_evt || (an_q && !(ctl_hit && cfg_wdata[ST_AN]));
    end
  end

  assign sup_root = sup_q;
  assign usr_root = usr_q;
  assign en_sup   = en_q[1];
  assign en_usr   = en_q[0];

  always_comb begin
    stat_word        = '0;
    stat_word[ST_TF] = tf_q;
    stat_word[ST_PF] = pf_q;
    stat_word[ST_PR] = pr_q;
    stat_word[ST_AN] = an_q;
    stat_word[ST_SE] = en_q[1];
    stat_word[ST_UE] = en_q[0];
  end

  // R9
  table_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[ST_TF] && !(ctl_hit && cfg_wdata[ST_TF])) |=> stat_word[ST_TF]);
  // R9
  any_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[ST_AN] && !(ctl_hit && cfg_wdata[ST_AN])) |=> stat_word[ST_AN]);
  // R4
  table_fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_tf |=> (stat_word[ST_TF] && stat_word[ST_AN]));
  // R6
  prot_fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pr |=> (stat_word[ST_PR] && stat_word[ST_AN]));
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
  import ptw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_va,
  input  logic           req_super,
  input  logic           req_write,
  input  logic [FNW-1:0] sup_root,
  input  logic [FNW-1:0] usr_root,
  input  logic           en_sup,
  input  logic           en_usr,
  output logic           done,
  output logic [AW-1:0]  rsp_pa,
  output logic [1:0]     rsp_fault,
  output logic           rsp_inhibit,
  output logic           fault_evt,
  output logic [1:0]     fault_kind,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  input  logic [AW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  typedef enum logic [2:0] {S_IDLE, S_ROOT, S_LEAF, S_WB, S_DONE} st_e;

  st_e            st;
  logic [AW-1:0]  va_q;
  logic           wr_q;
  logic [FNW-1:0] root_q;
  logic [FNW-1:0] tbl_q;
  logic           root_ro_q;
  logic [AW-1:0]  new_q;
  logic [AW-1:0]  pa_q;
  logic           nc_q;
  fault_e         flt_q;

  logic           accept, pass_thru;
  logic           root_bad, leaf_bad, leaf_prot;
  logic           leaf_ok, prot_hit, need_wb, nc_w;
  logic [AW-1:0]  leaf_new, pa_w;

  ptw_leaf_eval u_eval (
    .root_ro  (root_ro_q),
    .leaf     (mem_rdata),
    .va       (va_q),
    .wr       (wr_q),
    .leaf_ok  (leaf_ok),
    .prot_hit (prot_hit),
    .leaf_new (leaf_new),
    .need_wb  (need_wb),
    .pa       (pa_w),
    .nc       (nc_w)
  );

  assign req_ready = (st == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign pass_thru = req_super ? !en_sup : !en_usr;

  assign root_bad  = (st == S_ROOT) && mem_ack && !mem_rdata[ROOT_V];
  assign leaf_bad  = (st == S_LEAF) && mem_ack && !leaf_ok;
  assign leaf_prot = (st == S_LEAF) && mem_ack && leaf_ok && prot_hit;
  assign fault_evt = root_bad || leaf_bad || leaf_prot;
  assign fault_kind = root_bad ? FLT_TABLE : (leaf_bad ? FLT_PAGE : FLT_PROT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      root_q    <= '0;
      tbl_q     <= '0;
      root_ro_q <= 1'b0;
      new_q     <= '0;
      pa_q      <= '0;
      nc_q      <= 1'b0;
      flt_q     <= FLT_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          root_q <= req_super ? sup_root : usr_root;
          pa_q   <= req_va;
          nc_q   <= 1'b0;
          flt_q  <= FLT_NONE;
          st     <= pass_thru ? S_DONE : S_ROOT;
        end
        S_ROOT: if (mem_ack) begin
          tbl_q     <= mem_rdata[AW-1:PGW];
          root_ro_q <= mem_rdata[ROOT_RO];
          if (root_bad) begin
            flt_q <= FLT_TABLE;
            pa_q  <= '0;
            st    <= S_DONE;
          end else begin
            st <= S_LEAF;
          end
        end
        S_LEAF: if (mem_ack) begin
          if (leaf_bad || leaf_prot) begin
            flt_q <= leaf_bad ? FLT_PAGE : FLT_PROT;
            pa_q  <= '0;
            st    <= S_DONE;
          end else begin
            pa_q  <= pa_w;
            nc_q  <= nc_w;
            new_q <= leaf_new;
            st    <= need_wb ? S_WB : S_DONE;
          end
        end
        S_WB:   if (mem_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done        = (st == S_DONE);
  assign rsp_pa      = pa_q;
  assign rsp_fault   = flt_q;
  assign rsp_inhibit = nc_q;
  assign mem_req     = (st == S_ROOT) || (st == S_LEAF) || (st == S_WB);
  assign mem_we      = (st == S_WB);
  assign mem_addr    = (st == S_ROOT) ? root_slot(root_q, va_q) : leaf_slot(tbl_q, va_q);
  assign mem_wdata   = new_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R8
  wb_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[LEAF_REF]);
  // R4
  fault_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (done && rsp_fault != FLT_NONE && rsp_pa == '0));
  // R6
  prot_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_prot |=> !mem_we);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [FNW-1:0] cfg_wdata,
  output logic [SW-1:0]  stat_word,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_va,
  input  logic           req_super,
  input  logic           req_write,
  output logic           done,
  output logic [AW-1:0]  rsp_pa,
  output logic [1:0]     rsp_fault,
  output logic           rsp_inhibit,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  input  logic [AW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  logic [FNW-1:0] sup_root, usr_root;
  logic           en_sup, en_usr;
  logic           fault_evt;
  logic [1:0]     fault_kind;

  ptw_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .fault_evt  (fault_evt),
    .fault_kind (fault_kind),
    .sup_root   (sup_root),
    .usr_root   (usr_root),
    .en_sup     (en_sup),
    .en_usr     (en_usr),
    .stat_word  (stat_word)
  );

  ptw_walk u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_va      (req_va),
    .req_super   (req_super),
    .req_write   (req_write),
    .sup_root    (sup_root),
    .usr_root    (usr_root),
    .en_sup      (en_sup),
    .en_usr      (en_usr),
    .done        (done),
    .rsp_pa      (rsp_pa),
    .rsp_fault   (rsp_fault),
    .rsp_inhibit (rsp_inhibit),
    .fault_evt   (fault_evt),
    .fault_kind  (fault_kind),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack)
  );

  // R2
  pass_thru_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_super ? !stat_word[ST_SE] : !stat_word[ST_UE]))
      |=> (done && !mem_req));
endmodule

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [19:0] cfg_wdata = '0;
  logic [15:0] stat_word;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_super = 1'b0;
  logic        req_write = 1'b0;
  logic        done;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        rsp_inhibit;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [31:0] mem [logic [31:0]];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top u_ptw_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stat_word(stat_word), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_super(req_super),
    .req_write(req_write), .done(done), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_inhibit(rsp_inhibit), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        rd_cnt = rd_cnt + 1;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issues one request and returns the cycles from acceptance to done
  task automatic run_req(input logic [31:0] va, input logic sup, input logic wr,
                         output int lat);
    bit ready_err;
    ready_err = 0;
    @(negedge clk);
    req_va = va; req_super = sup; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (req_ready) ready_err = 1;
      @(negedge clk);
      lat++;
    end
    check("R10 ready low while busy", {31'b0, ready_err}, 32'h0);
  endtask

  localparam logic [19:0] SUP_ROOT = 20'h00010;
  localparam logic [19:0] USR_ROOT = 20'h00020;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lat;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 ready", {31'b0, req_ready}, 32'h1);
    check("R1 done", {31'b0, done}, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
    check("R1 status", {16'b0, stat_word}, 32'h0);

    // R2: untranslated with enables clear after reset
    run_req(32'h1234_5678, 1'b1, 1'b0, lat);
    check("R2 latency", lat, 1);
    check("R2 pa", rsp_pa, 32'h1234_5678);
    check("R2 fault", {30'b0, rsp_fault}, 0);
    check("R2 no memory", rd_cnt + wr_cnt, 0);

    cfg_write(2'd0, SUP_ROOT);
    cfg_write(2'd1, USR_ROOT);
    cfg_write(2'd2, 20'h00003);
    check("R9 enables loaded", {16'b0, stat_word}, 32'h3);

    n = 0;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int sk = 0; sk < 3; sk++)
          for (int pk = 0; pk < 3; pk++)
            for (int rm = 0; rm < 3; rm++)
              for (int ci = 0; ci < 2; ci++) begin : sweep
                logic [9:0]  si, pi;
                logic [11:0] off;
                logic [19:0] ptf, pgf;
                logic [31:0] va, radr, ladr, rent, lent, lexp, st_exp;
                bit sv, sro, pv, pro, wb;
                int exp_lat, exp_flt, rd0, wr0;
                si  = 10'((n * 7 + 3) & 1023);
                pi  = 10'((n * 13 + 5) & 1023);
                off = 12'((n * 37) & 4095);
                ptf = 20'h00100 + 20'(n);
                pgf = 20'hA0000 + 20'(n);
                va  = {si, pi, off};
                sv  = (sk != 0); sro = (sk == 2);
                pv  = (pk != 0); pro = (pk == 2);
                radr = {(s != 0) ? SUP_ROOT : USR_ROOT, si, 2'b00};
                ladr = {ptf, pi, 2'b00};
                // root: frame, bit3 one, bit2 ro, bit1 valid, bit0 opposite of valid
                rent = {ptf, 8'h00, 1'b1, sro, sv, !sv};
                // leaf: frame, sw bits, bit6 nc, bit4 dirty, bit3 ref, bit2 ro, bit1 junk, bit0 valid
                lent = {pgf, 5'b10101, ci[0], 1'b0, rm == 2, rm != 0, pro, !pv, pv};
                mem[radr] = rent;
                mem[ladr] = lent;
                lexp = lent | 32'h8 | ((w != 0) ? 32'h10 : 32'h0);
                wb = 0;
                if (!sv) begin exp_flt = 1; exp_lat = 3; st_exp = 32'h8008 | 3; end
                else if (!pv) begin exp_flt = 2; exp_lat = 5; st_exp = 32'h4008 | 3; end
                else if (w != 0 && (sro || pro)) begin exp_flt = 3; exp_lat = 5; st_exp = 32'h2008 | 3; end
                else begin
                  exp_flt = 0; st_exp = 3;
                  wb = (lexp != lent);
                  exp_lat = wb ? 7 : 5;
                end
                rd0 = rd_cnt; wr0 = wr_cnt;
                run_req(va, s[0], w[0], lat);
                if (exp_flt == 1) begin
                  // R4
                  check("R4 table fault code", {30'b0, rsp_fault}, 1);
                  check("R4 latency", lat, exp_lat);
                  check("R4 status", {16'b0, stat_word}, st_exp);
                  check("R3 one read", rd_cnt - rd0, 1);
                end else if (exp_flt == 2) begin
                  // R5
                  check("R5 page fault code", {30'b0, rsp_fault}, 2);
                  check("R5 latency", lat, exp_lat);
                  check("R5 status", {16'b0, stat_word}, st_exp);
                end else if (exp_flt == 3) begin
                  // R6
                  check("R6 prot fault code", {30'b0, rsp_fault}, 3);
                  check("R6 latency", lat, exp_lat);
                  check("R6 status", {16'b0, stat_word}, st_exp);
                  check("R6 no write", wr_cnt - wr0, 0);
                  check("R6 entry unchanged", mem[ladr], lent);
                end else begin
                  // R3 R5 R7
                  check("R7 fault none", {30'b0, rsp_fault}, 0);
                  check("R7 pa", rsp_pa, {pgf, off});
                  check("R7 inhibit", {31'b0, rsp_inhibit}, ci);
                  check("R3 R5 two reads", rd_cnt - rd0, 2);
                  // R8
                  check("R8 latency", lat, exp_lat);
                  check("R8 write count", wr_cnt - wr0, wb ? 1 : 0);
                  check("R8 stored entry", mem[ladr], lexp);
                  check("R7 status", {16'b0, stat_word}, st_exp);
                end
                if (exp_flt != 0) begin
                  check("R7 fault pa zero", rsp_pa, 0);
                  check("R7 fault nc zero", {31'b0, rsp_inhibit}, 0);
                end
                cfg_write(2'd2, 20'h0E00B);
                n++;
              end

    // R9: flags persist across a good access, then clear bit by bit
    begin : sticky
      logic [31:0] radr;
      radr = {SUP_ROOT, 10'd1000, 2'b00};
      mem[radr] = 32'h0000_0009;           // invalid root entry
      run_req({10'd1000, 10'd0, 12'h0}, 1'b1, 1'b0, lat);
      check("R9 table flag set", {16'b0, stat_word}, 32'h8008 | 3);
      mem[radr] = 32'h0030_000A;
      mem[{20'h00300, 10'd4, 2'b00}] = 32'h0077_7009;
      run_req({10'd1000, 10'd4, 12'h55}, 1'b1, 1'b0, lat);
      check("R9 flag survives success", {16'b0, stat_word}, 32'h8008 | 3);
      check("R7 pa after fault", rsp_pa, 32'h0077_7055);
      cfg_write(2'd2, 20'h08003);
      check("R9 clear only bit15", {16'b0, stat_word}, 32'h0008 | 3);
      cfg_write(2'd2, 20'h00009);
      check("R9 clear bit3 load enables", {16'b0, stat_word}, 32'h1);
    end

    // R2: supervisor untranslated, user still translated
    begin : bypass
      int rd0;
      rd0 = rd_cnt;
      run_req(32'hFEDC_BA98, 1'b1, 1'b1, lat);
      check("R2 sup bypass pa", rsp_pa, 32'hFEDC_BA98);
      check("R2 sup bypass latency", lat, 1);
      check("R2 sup bypass no read", rd_cnt - rd0, 0);
      mem[{USR_ROOT, 10'd999, 2'b00}] = 32'h0;
      run_req({10'd999, 10'd0, 12'h0}, 1'b0, 1'b0, lat);
      check("R2 user still walks", {30'b0, rsp_fault}, 1);
      cfg_write(2'd2, 20'h0E00A);
      rd0 = rd_cnt;
      run_req(32'h0000_1FFF, 1'b0, 1'b0, lat);
      check("R2 user bypass pa", rsp_pa, 32'h0000_1FFF);
      check("R2 user bypass no read", rd_cnt - rd0, 0);
      @(negedge clk);
      check("R10 done single cycle", {31'b0, done}, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule